// File: doc/BRIEF.md
# Idle Wake-up Controller with Stabilization Timer

This block holds a small processor core in a low-power idle state and decides how the core comes back. Software asks for idle with a one-cycle request while the core runs. From then on the block watches three kinds of event: a non-maskable interrupt line, a vector of maskable interrupt requests (each with a mask bit and a 3-bit priority), and the synchronous reset. Any non-maskable request, or any unmasked maskable request of any priority, ends idle. The block then runs a dedicated stabilization counter and returns the core to run only when that counter reaches its last count.

At the moment of wake-up the block picks the winning source and decides whether the core should take it. It compares the winner with the priority of the interrupt that was in service when idle was entered, and it looks at the interrupt-enable state. When the counter expires, the block issues a one-cycle result. The result says whether the request is acknowledged, which request it is, and whether the core simply resumes at the next instruction. When the core resumes without taking the request, the result also reports that the request stays pending.

A 3-bit select register sets the stabilization length. Its value is sampled when stabilization starts. Reset returns the block to run at once and reloads the select register.

Top module: `iwc_top`

## Requirements
- R1: After reset, `run_o` is 1 and `done_o`, `ack_o`, `ack_nmi_o`, `resume_next_o` and `held_o` are 0. The select register holds code 3, so the next stabilization lasts 2^(BASE_EXP+3) cycles.
- R2: A one-cycle `idle_req` while running drives `run_o` low on the next clock edge. While idle, a maskable request whose `irq_mask` bit is 1 (1 means masked) does not end idle.
- R3: While idle, `nmi_req` or any request with its mask bit 0, whatever its priority, starts stabilization. `run_o` returns to 1 exactly L clock edges after the edge that sampled the wake source, where L is the selected length.
- R4: Select codes 0 to 4 give L = 2^(BASE_EXP+code). Codes 5, 6 and 7 give 2^(BASE_EXP+3). The code is written with `sel_we`. A write made during stabilization leaves the running count unchanged and applies from the next wake-up.
- R5: `done_o` is a one-cycle pulse, high in the cycle in which `run_o` returns to 1. `ack_o`, `ack_nmi_o`, `resume_next_o` and `held_o` are 0 outside that cycle.
- R6: A non-maskable wake source always wins. It is acknowledged (`ack_o`=1, `ack_nmi_o`=1, `resume_next_o`=0, `win_id_o`=0) whatever the state of `int_enable` and of the in-service priority.
- R7: Among unmasked maskable requests, the lowest priority value wins, and a tie goes to the lower index. The winner's index appears on `win_id_o` with `done_o`. Priority of request i is `irq_prio[3*i+2:3*i]`.
- R8: A maskable winner is acknowledged (`ack_o`=1, `resume_next_o`=0) only when `int_enable` is 1 and either `svc_active` is 0 or its priority value is numerically smaller than `svc_prio`.
- R9: A maskable winner that is not acknowledged, including one of equal priority, gives `ack_o`=0, `resume_next_o`=1 and `held_o`=1. This marks the request as left pending.
- R10: Wake sources or priority changes that arrive during stabilization neither restart the count nor change the captured winner or decision.
- R11: Reset during idle or stabilization sets `run_o` to 1 on the next edge with no `done_o` pulse, and restores select code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (pin or watchdog) |
| idle_req | input | 1 | One-cycle request from software to enter idle |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | NUM_IRQ | Maskable interrupt requests |
| irq_mask | input | NUM_IRQ | Mask bits, 1 = masked |
| irq_prio | input | NUM_IRQ*PRIO_W | Packed priorities, lower value = higher priority |
| int_enable | input | 1 | Core interrupt-enable state |
| svc_active | input | 1 | An interrupt was in service when idle was entered |
| svc_prio | input | PRIO_W | Priority of the in-service interrupt |
| sel_we | input | 1 | Write strobe for the stabilization select register |
| sel_wdata | input | 3 | New stabilization select code |
| run_o | output | 1 | Core in normal run |
| done_o | output | 1 | One-cycle pulse at the end of stabilization |
| ack_o | output | 1 | Waking request is acknowledged |
| ack_nmi_o | output | 1 | Acknowledged request is the non-maskable one |
| win_id_o | output | ID_W | Index of the winning maskable request |
| resume_next_o | output | 1 | Core continues at the next instruction |
| held_o | output | 1 | Winning maskable request stays pending |

## Verification
`run_o` falls on the first edge after `idle_req` is sampled. Reset takes effect on the first edge after it is sampled. The return to run and every wake-up result appear together, L edges after the edge that saw the wake source. The bench drives inputs on falling edges and counts falling edges from the stimulus until `run_o` rises. It expects L+1 and reads all result fields on that same falling edge. It then checks the next falling edge for the pulse to be gone. Injected events during stabilization are placed at a fixed falling-edge count, so the expected length and winner stay known exactly.

// File: rtl/iwc_pkg.sv
package iwc_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_STAB = 2'd2
  } iwc_state_e;

  // Select code to extra exponent: codes 0..4 direct, the rest fall back to 3.
  function automatic logic [2:0] sel_to_shift(input logic [SEL_W-1:0] code);
    if (code <= 3'd4) return code;
    else              return 3'd3;
  endfunction

endpackage

// File: rtl/iwc_arbiter.sv
module iwc_arbiter #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 3
) (
  input  logic [NUM_IRQ-1:0]        req,
  input  logic [NUM_IRQ-1:0]        mask,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  output logic                      any_o,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o
);

  logic [NUM_IRQ-1:0] live;
  logic [PRIO_W-1:0]  prio_arr [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
    assign live[g]     = req[g] & ~mask[g];
    assign prio_arr[g] = prio[g*PRIO_W +: PRIO_W];
  end

  // Strict compare keeps the lower index on equal priority.
  always_comb begin
    any_o  = 1'b0;
    id_o   = '0;
    prio_o = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (live[i] && (!any_o || (prio_arr[i] < prio_o))) begin
        any_o  = 1'b1;
        id_o   = ID_W'(i);
        prio_o = prio_arr[i];
      end
    end
  end

endmodule

// File: rtl/iwc_ack_decide.sv
module iwc_ack_decide #(
  parameter int PRIO_W = 3
) (
  input  logic              nmi,
  input  logic              any_mask,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              int_enable,
  input  logic              svc_active,
  input  logic [PRIO_W-1:0] svc_prio,
  output logic              take_o,
  output logic              held_o
);

  logic outranks;

  assign outranks = !svc_active || (win_prio < svc_prio);

  always_comb begin
    if (nmi) begin
      take_o = 1'b1;
      held_o = 1'b0;
    end else begin
      take_o = any_mask && int_enable && outranks;
      held_o = any_mask && !(int_enable && outranks);
    end
  end

endmodule

// File: rtl/iwc_stab_timer.sv
module iwc_stab_timer
  import iwc_pkg::*;
#(
  parameter int               BASE_EXP = 13,
  parameter logic [SEL_W-1:0] DEF_SEL  = 3'd3,
  localparam int              CNT_W    = BASE_EXP + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             start,
  input  logic             active,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [SEL_W-1:0] sel_q;
  logic [2:0]       shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= DEF_SEL;
    else if (sel_we) sel_q <= sel_wdata;
  end

  // Length is frozen at start so later writes cannot disturb a running count.
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= sel_to_shift(DEF_SEL);
      cnt_q   <= '0;
    end else if (start) begin
      shift_q <= sel_to_shift(sel_q);
      cnt_q   <= '0;
    end else if (active && !expire_o) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign last_val = (CNT_W'(1) << (BASE_EXP + int'(shift_q))) - CNT_W'(1);
  assign expire_o = active && (cnt_q == last_val);
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/iwc_top.sv
module iwc_top
  import iwc_pkg::*;
#(
  parameter int               NUM_IRQ  = 8,
  parameter int               PRIO_W   = 3,
  parameter int               BASE_EXP = 13,
  parameter logic [SEL_W-1:0] DEF_SEL  = 3'd3,
  localparam int              ID_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int              CNT_W    = BASE_EXP + 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      idle_req,
  input  logic                      nmi_req,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ-1:0]        irq_mask,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic                      int_enable,
  input  logic                      svc_active,
  input  logic [PRIO_W-1:0]         svc_prio,
  input  logic                      sel_we,
  input  logic [SEL_W-1:0]          sel_wdata,
  output logic                      run_o,
  output logic                      done_o,
  output logic                      ack_o,
  output logic                      ack_nmi_o,
  output logic [ID_W-1:0]           win_id_o,
  output logic                      resume_next_o,
  output logic                      held_o
);

  iwc_state_e        state_q, state_n;
  logic              any_mask;
  logic [ID_W-1:0]   win_id;
  logic [PRIO_W-1:0] win_prio;
  logic              take, held;
  logic              wake, start, expire;
  logic [CNT_W-1:0]  stab_cnt;

  logic              cap_take, cap_nmi, cap_held;
  logic [ID_W-1:0]   cap_id;

  iwc_arbiter #(
    .NUM_IRQ (NUM_IRQ),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W)
  ) u_arb (
    .req    (irq_req),
    .mask   (irq_mask),
    .prio   (irq_prio),
    .any_o  (any_mask),
    .id_o   (win_id),
    .prio_o (win_prio)
  );

  iwc_ack_decide #(
    .PRIO_W (PRIO_W)
  ) u_dec (
    .nmi        (nmi_req),
    .any_mask   (any_mask),
    .win_prio   (win_prio),
    .int_enable (int_enable),
    .svc_active (svc_active),
    .svc_prio   (svc_prio),
    .take_o     (take),
    .held_o     (held)
  );

  iwc_stab_timer #(
    .BASE_EXP (BASE_EXP),
    .DEF_SEL  (DEF_SEL)
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .sel_we    (sel_we),
    .sel_wdata (sel_wdata),
    .start     (start),
    .active    (state_q == ST_STAB),
    .expire_o  (expire),
    .cnt_o     (stab_cnt)
  );

  assign wake  = nmi_req | any_mask;
  assign start = (state_q == ST_IDLE) && wake;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RUN:  if (idle_req) state_n = ST_IDLE;
      ST_IDLE: if (wake)     state_n = ST_STAB;
      ST_STAB: if (expire)   state_n = ST_RUN;
      default:               state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      run_o   <= 1'b1;
    end else begin
      state_q <= state_n;
      run_o   <= (state_n == ST_RUN);
    end
  end

  // Decision is taken from the sources present at the wake edge only.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_take <= 1'b0;
      cap_nmi  <= 1'b0;
      cap_held <= 1'b0;
      cap_id   <= '0;
    end else if (start) begin
      cap_take <= take;
      cap_nmi  <= nmi_req;
      cap_held <= held;
      cap_id   <= nmi_req ? '0 : win_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !expire) begin
      done_o        <= 1'b0;
      ack_o         <= 1'b0;
      ack_nmi_o     <= 1'b0;
      win_id_o      <= '0;
      resume_next_o <= 1'b0;
      held_o        <= 1'b0;
    end else begin
      done_o        <= 1'b1;
      ack_o         <= cap_take;
      ack_nmi_o     <= cap_nmi;
      win_id_o      <= cap_id;
      resume_next_o <= !cap_take;
      held_o        <= cap_held;
    end
  end

endmodule

// File: rtl/iwc_checker.sv
module iwc_checker
  import iwc_pkg::*;
#(
  parameter int  BASE_EXP = 13,
  localparam int CNT_W    = BASE_EXP + 5
) (
  input logic             clk,
  input logic             rst,
  input iwc_state_e       state,
  input logic             wake,
  input logic             expire,
  input logic [CNT_W-1:0] cnt,
  input logic             run_o,
  input logic             done_o,
  input logic             ack_o,
  input logic             ack_nmi_o,
  input logic             resume_next_o,
  input logic             held_o
);

  AST_RESET_TO_RUN: assert property (@(posedge clk) rst |=> (run_o && !done_o)); // R11

  AST_WAKE_STARTS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && wake) |=> (state == ST_STAB && cnt == '0)); // R3

  AST_COUNT_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STAB && !expire) |=> (cnt == $past(cnt) + 1'b1)); // R10

  AST_DONE_WITH_RUN: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run_o && $past(state) == ST_STAB)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5

  AST_QUIET_OUTSIDE_DONE: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> !(ack_o || ack_nmi_o || resume_next_o || held_o)); // R5

  AST_NMI_IS_ACK: assert property (@(posedge clk) disable iff (rst)
    ack_nmi_o |-> (ack_o && !resume_next_o)); // R6

  AST_ACK_XOR_RESUME: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ack_o != resume_next_o)); // R8

  AST_HELD_NOT_ACK: assert property (@(posedge clk) disable iff (rst)
    held_o |-> (resume_next_o && !ack_o)); // R9

endmodule

bind iwc_top iwc_checker #(.BASE_EXP(BASE_EXP)) u_iwc_chk (
  .clk           (clk),
  .rst           (rst),
  .state         (state_q),
  .wake          (wake),
  .expire        (expire),
  .cnt           (stab_cnt),
  .run_o         (run_o),
  .done_o        (done_o),
  .ack_o         (ack_o),
  .ack_nmi_o     (ack_nmi_o),
  .resume_next_o (resume_next_o),
  .held_o        (held_o)
);

// File: tb/test_iwc_top.sv
module test_iwc_top;

  localparam int NIRQ = 8;
  localparam int PW   = 3;
  localparam int BEXP = 2;
  localparam int IDW  = 3;

  // Fixed priorities, index 7 down to 0.
  localparam logic [NIRQ*PW-1:0] PRIO_MAP =
    {3'd1, 3'd0, 3'd6, 3'd2, 3'd4, 3'd5, 3'd4, 3'd3};

  typedef struct packed {
    logic       nmi;
    logic [7:0] req;
    logic [7:0] msk;
    logic       ie;
    logic       sva;
    logic [2:0] svp;
    logic       e_ack;
    logic       e_nmi;
    logic [2:0] e_id;
    logic       e_held;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0},
    '{1'b0, 8'h01, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0},
    '{1'b0, 8'h84, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd7, 1'b0},
    '{1'b0, 8'h0A, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1, 1'b0},
    '{1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0, 3'd4, 1'b0},
    '{1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 3'd4, 1'b1},
    '{1'b0, 8'h20, 8'h00, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 3'd5, 1'b1},
    '{1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1},
    '{1'b0, 8'h41, 8'h40, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0},
    '{1'b1, 8'h40, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0},
    '{1'b0, 8'h80, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 3'd7, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            idle_req = 1'b0;
  logic            nmi_req = 1'b0;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NIRQ-1:0] irq_mask = '0;
  logic            int_enable = 1'b0;
  logic            svc_active = 1'b0;
  logic [PW-1:0]   svc_prio = '0;
  logic            sel_we = 1'b0;
  logic [2:0]      sel_wdata = '0;
  logic            run_o, done_o, ack_o, ack_nmi_o, resume_next_o, held_o;
  logic [IDW-1:0]  win_id_o;

  always #5 clk = ~clk;

  iwc_top #(
    .NUM_IRQ  (NIRQ),
    .PRIO_W   (PW),
    .BASE_EXP (BEXP)
  ) i_iwc_top (
    .clk           (clk),
    .rst           (rst),
    .idle_req      (idle_req),
    .nmi_req       (nmi_req),
    .irq_req       (irq_req),
    .irq_mask      (irq_mask),
    .irq_prio      (PRIO_MAP),
    .int_enable    (int_enable),
    .svc_active    (svc_active),
    .svc_prio      (svc_prio),
    .sel_we        (sel_we),
    .sel_wdata     (sel_wdata),
    .run_o         (run_o),
    .done_o        (done_o),
    .ack_o         (ack_o),
    .ack_nmi_o     (ack_nmi_o),
    .win_id_o      (win_id_o),
    .resume_next_o (resume_next_o),
    .held_o        (held_o)
  );

  int n_run  = 0;
  int n_fail = 0;

  int         r_n;
  logic       r_done, r_ack, r_nmi, r_resume, r_held;
  logic [2:0] r_id;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input int code);
    return 1 << (BEXP + ((code <= 4) ? code : 3));
  endfunction

  task automatic write_sel(input int code);
    @(negedge clk);
    sel_we    = 1'b1;
    sel_wdata = 3'(code);
    @(negedge clk);
    sel_we    = 1'b0;
  endtask

  task automatic enter_idle();
    @(negedge clk);
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
  endtask

  // kind: 0 none, 1 extra wake sources, 2 select write of code 0, 3 reset
  task automatic wake_and_wait(input vec_t v, input int kind, input int at);
    nmi_req    = v.nmi;
    irq_req    = v.req;
    irq_mask   = v.msk;
    int_enable = v.ie;
    svc_active = v.sva;
    svc_prio   = v.svp;
    r_n = 0;
    do begin
      @(negedge clk);
      r_n++;
      if (r_n == at) begin
        if (kind == 1) begin
          nmi_req = 1'b1;
          irq_req = irq_req | 8'h40;
        end else if (kind == 2) begin
          sel_we    = 1'b1;
          sel_wdata = 3'd0;
        end else if (kind == 3) begin
          rst = 1'b1;
        end
      end else if (r_n == at + 1) begin
        sel_we = 1'b0;
        rst    = 1'b0;
      end
    end while (!run_o && r_n < 1000);
    r_done   = done_o;
    r_ack    = ack_o;
    r_nmi    = ack_nmi_o;
    r_resume = resume_next_o;
    r_held   = held_o;
    r_id     = win_id_o;
    nmi_req  = 1'b0;
    irq_req  = '0;
    irq_mask = '0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 run_o after reset", int'(run_o), 1);
    chk("R1 pulses quiet after reset",
        int'({done_o, ack_o, ack_nmi_o, resume_next_o, held_o}), 0);

    // R2: entry and masked requests ignored
    enter_idle();
    chk("R2 run_o low after idle_req", int'(run_o), 0);
    irq_req  = 8'hFF;
    irq_mask = 8'hFF;
    begin
      int woke = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (run_o || done_o) woke = 1;
      end
      chk("R2 masked requests keep idle", woke, 0);
    end
    wake_and_wait(VECS[1], 0, 0);
    chk("R1 default length", r_n, exp_len(3) + 1);

    // R3 R5 R6 R7 R8 R9: vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = VECS[i].e_nmi ? "R6" : (VECS[i].e_ack ? "R8" : "R9");
      enter_idle();
      wake_and_wait(VECS[i], 0, 0);
      chk($sformatf("R3 length vec%0d", i), r_n, exp_len(3) + 1);
      chk($sformatf("R5 done vec%0d", i), int'(r_done), 1);
      chk($sformatf("%s ack vec%0d", tag, i), int'(r_ack), int'(VECS[i].e_ack));
      chk($sformatf("%s nmi vec%0d", tag, i), int'(r_nmi), int'(VECS[i].e_nmi));
      chk($sformatf("%s resume vec%0d", tag, i), int'(r_resume), int'(!VECS[i].e_ack));
      chk($sformatf("R9 held vec%0d", i), int'(r_held), int'(VECS[i].e_held));
      chk($sformatf("R7 id vec%0d", i), int'(r_id), int'(VECS[i].e_id));
      @(negedge clk);
      chk($sformatf("R5 pulse ends vec%0d", i), int'(done_o), 0);
    end

    // R4: every select code
    for (int c = 0; c < 8; c++) begin
      write_sel(c);
      enter_idle();
      wake_and_wait(VECS[0], 0, 0);
      chk($sformatf("R4 length code%0d", c), r_n, exp_len(c) + 1);
    end

    // R4: write during stabilization applies only from the next wake
    write_sel(1);
    enter_idle();
    wake_and_wait(VECS[0], 2, 2);
    chk("R4 mid-count write ignored", r_n, exp_len(1) + 1);
    enter_idle();
    wake_and_wait(VECS[0], 0, 0);
    chk("R4 written code used next", r_n, exp_len(0) + 1);

    // R10: new sources during stabilization
    write_sel(3);
    enter_idle();
    wake_and_wait(VECS[6], 1, 5);
    chk("R10 length kept", r_n, exp_len(3) + 1);
    chk("R10 ack unchanged", int'(r_ack), 0);
    chk("R10 nmi unchanged", int'(r_nmi), 0);
    chk("R10 winner unchanged", int'(r_id), 5);
    chk("R10 held unchanged", int'(r_held), 1);

    // R11: reset during stabilization, then default select restored
    write_sel(0);
    enter_idle();
    wake_and_wait(VECS[0], 3, 3);
    chk("R11 run one edge after reset", r_n, 4);
    chk("R11 no done on reset", int'(r_done), 0);
    enter_idle();
    wake_and_wait(VECS[0], 0, 0);
    chk("R11 select reloaded", r_n, exp_len(3) + 1);

    // R11: reset during idle
    enter_idle();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 run after reset in idle", int'(run_o), 1);
    chk("R11 no done in idle reset", int'(done_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule